// File: doc/BRIEF.md
# Two-Address Configuration Window

This block lets a host reach a bank of 8-bit configuration registers through only two I/O addresses. The first address holds a pointer (the selector); the second is a window onto whichever register the selector names. A host writes the selector, then reads or writes the window. The register bank itself lives outside the block and is reached through a small port carrying the selected index, a write pulse, write data, the current contents and a mask of implemented bits.

Two base-select strap pins are captured while reset is held. They choose where the pair sits on the bus and whether it is usable straight away. Two motherboard codes place the pair at a fixed address with the window one above the selector, and open it at once. The other two codes select plug-and-play decoding, where the pair starts locked. It stays locked until an external unlock pulse arrives from the key-sequence logic, which lies outside this block.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the selector holds 00h. Configuration is open when strap_base[1] is 1 and locked when it is 0.
- R2: A write to the selector address loads bus_wdata into the selector. A read of the selector address returns that value with bus_rdata_oe high.
- R3: A write to the window address pulses cfg_wr for one cycle, with cfg_idx equal to the selector. cfg_wdata equals bus_wdata with every bit clear in cfg_mask forced to 0.
- R4: A read of the window address returns cfg_rdata with bits clear in cfg_mask read as 0, and bus_rdata_oe high.
- R5: strap_base = 2'b10 puts the selector at 015Ch and the window at 015Dh.
- R6: strap_base = 2'b11 puts the selector at 002Eh and the window at 002Fh.
- R7: With strap_base[1] = 0 the pair is locked after reset. While locked, writes change nothing and raise no cfg_wr, and reads leave bus_rdata_oe low with bus_rdata at FFh.
- R8: A one-cycle pnp_unlock pulse opens a locked pair until the next reset. The plug-and-play pair then decodes on address bits 11:0 only, with the selector at PNP_SEL (default 279h) and the window at PNP_SEL+1.
- R9: In motherboard mode all of bits 15:1 must match the base, and bit 0 picks selector (0) or window (1). Any other address raises no cfg_wr, gives bus_rdata_oe low and bus_rdata FFh.
- R10: The straps are captured only while rst_n is low. Changing strap_base after reset does not move or relock the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Read data, FFh when not driven |
| bus_rdata_oe | output | 1 | High when the block answers a read |
| strap_base | input | 2 | Base-select strap pins |
| pnp_unlock | input | 1 | Unlock pulse from the key-sequence logic |
| cfg_idx | output | 8 | Register index selected by the selector |
| cfg_wr | output | 1 | Write pulse to the register bank |
| cfg_wdata | output | 8 | Write data with reserved bits cleared |
| cfg_rdata | input | 8 | Contents of the selected register |
| cfg_mask | input | 8 | Implemented-bit mask of the selected register |

## Verification
The hardest state to reach is a locked pair that has been opened: a write made while locked must leave no trace once the pair is open. The bench resets with a plug-and-play strap and writes the selector while locked. It then pulses the unlock input and reads the selector back, expecting the reset value. It also flips the strap pins after a motherboard reset and shows that the original address still answers.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and helpers for the configuration window.
// Assumes strap code bit 1 set means motherboard mode.
package cfgp_pkg;

    localparam int unsigned CFGP_DW = 8;

    // Strap code decoded into an operating mode
    typedef enum logic [1:0] {
        MODE_PNP_A = 2'b00,
        MODE_PNP_B = 2'b01,
        MODE_MB_LO = 2'b10,
        MODE_MB_HI = 2'b11
    } cfgp_mode_e;

    // True when the strap code selects fixed motherboard decoding
    function automatic logic is_mb(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/cfgp_strap.sv
// Strap capture and lock state.
// Samples the straps on every clock while rst_n is low, so the value present at
// the last reset edge is kept. Lock starts set for plug-and-play codes and clears
// on an unlock pulse only.
module cfgp_strap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_in,
    input  logic       unlock,
    output logic [1:0] strap_q,
    output logic       locked
);
    import cfgp_pkg::*;

    // Capture straps during reset, hold them afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_in;
    end

    // Lock starts per strap code and only ever clears afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)                 locked <= !is_mb(strap_in);
        else if (unlock && locked)  locked <= 1'b0;
    end

endmodule

// File: rtl/cfgp_decode.sv
// Address decode for the selector/window pair.
// Motherboard mode compares address bits above bit 0 against a strap-chosen base
// and uses bit 0 as the selector/window pick. Plug-and-play mode compares the low
// PNP_BITS address bits against two fixed addresses.
module cfgp_decode #(
    parameter int unsigned         AW       = 16,
    parameter int unsigned         PNP_BITS = 12,
    parameter logic [AW-1:0]       MB_LO    = 16'h015C,
    parameter logic [AW-1:0]       MB_HI    = 16'h002E,
    parameter logic [PNP_BITS-1:0] PNP_SEL  = 12'h279
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    strap_q,
    output logic          sel_hit,
    output logic          win_hit
);
    import cfgp_pkg::*;

    localparam logic [PNP_BITS-1:0] PNP_WIN = PNP_SEL + 1'b1;

    logic [AW-1:0] mb_base;
    logic          mb_match;
    logic          pnp_sel_hit;
    logic          pnp_win_hit;

    // Pick the motherboard base from the captured strap
    always_comb begin
        mb_base  = (cfgp_mode_e'(strap_q) == MODE_MB_HI) ? MB_HI : MB_LO;
        mb_match = (addr[AW-1:1] == mb_base[AW-1:1]);
    end

    // Plug-and-play compare, narrowed when the decode width is below the bus width
    generate
        if (PNP_BITS < AW) begin : g_narrow
            always_comb begin
                pnp_sel_hit = (addr[PNP_BITS-1:0] == PNP_SEL);
                pnp_win_hit = (addr[PNP_BITS-1:0] == PNP_WIN);
            end
        end else begin : g_full
            always_comb begin
                pnp_sel_hit = (addr == AW'(PNP_SEL));
                pnp_win_hit = (addr == AW'(PNP_WIN));
            end
        end
    endgenerate

    // Select the hit pair for the active mode
    always_comb begin
        if (is_mb(strap_q)) begin
            sel_hit = mb_match && !addr[0];
            win_hit = mb_match &&  addr[0];
        end else begin
            sel_hit = pnp_sel_hit;
            win_hit = pnp_win_hit;
        end
    end

endmodule

// File: rtl/cfg_index_port.sv
// Top: selector/window configuration access port.
// Holds the selector register, gates bus accesses with the lock state, masks
// reserved bits on both directions and muxes read data. Assumes one-cycle strobes
// and a register bank that answers cfg_rdata/cfg_mask combinationally from cfg_idx.
module cfg_index_port #(
    parameter int unsigned         AW       = 16,
    parameter int unsigned         DW       = 8,
    parameter int unsigned         PNP_BITS = 12,
    parameter logic [AW-1:0]       MB_LO    = 16'h015C,
    parameter logic [AW-1:0]       MB_HI    = 16'h002E,
    parameter logic [PNP_BITS-1:0] PNP_SEL  = 12'h279
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    input  logic [1:0]    strap_base,
    input  logic          pnp_unlock,
    output logic [DW-1:0] cfg_idx,
    output logic          cfg_wr,
    output logic [DW-1:0] cfg_wdata,
    input  logic [DW-1:0] cfg_rdata,
    input  logic [DW-1:0] cfg_mask
);
    localparam logic [DW-1:0] IDLE_BUS = {DW{1'b1}};

    logic [1:0]    strap_q;
    logic          locked;
    logic          sel_hit;
    logic          win_hit;
    logic          idx_wr;
    logic [DW-1:0] idx_q;

    cfgp_strap u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_base),
        .unlock   (pnp_unlock),
        .strap_q  (strap_q),
        .locked   (locked)
    );

    cfgp_decode #(
        .AW       (AW),
        .PNP_BITS (PNP_BITS),
        .MB_LO    (MB_LO),
        .MB_HI    (MB_HI),
        .PNP_SEL  (PNP_SEL)
    ) u_decode (
        .addr    (bus_addr),
        .strap_q (strap_q),
        .sel_hit (sel_hit),
        .win_hit (win_hit)
    );

    // Qualify writes with the lock state
    always_comb begin
        idx_wr    = bus_wr && sel_hit && !locked;
        cfg_wr    = bus_wr && win_hit && !locked;
        cfg_wdata = bus_wdata & cfg_mask;
        cfg_idx   = idx_q;
    end

    // Selector register
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= bus_wdata;
    end

    // Read data mux; idle bus floats high
    always_comb begin
        bus_rdata_oe = bus_rd && !locked && (sel_hit || win_hit);
        if (!bus_rdata_oe) bus_rdata = IDLE_BUS;
        else if (sel_hit)  bus_rdata = idx_q;
        else               bus_rdata = cfg_rdata & cfg_mask;
    end

endmodule

// File: rtl/cfgp_checker.sv
// Checker: temporal properties of the configuration window, bound to the top.
module cfgp_checker #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          locked,
    input logic [1:0]    strap_q,
    input logic          idx_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rdata_oe,
    input logic          cfg_wr,
    input logic [DW-1:0] cfg_idx,
    input logic [DW-1:0] cfg_wdata,
    input logic [DW-1:0] cfg_mask
);
    // R7
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!cfg_wr && !bus_rdata_oe && !idx_wr));

    // R3
    reserved_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> ((cfg_wdata & ~cfg_mask) == '0));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cfg_idx == $past(bus_wdata)));

    // R10
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

    // R8
    stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !locked);

endmodule

bind cfg_index_port cfgp_checker #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .locked       (locked),
    .strap_q      (strap_q),
    .idx_wr       (idx_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata_oe (bus_rdata_oe),
    .cfg_wr       (cfg_wr),
    .cfg_idx      (cfg_idx),
    .cfg_wdata    (cfg_wdata),
    .cfg_mask     (cfg_mask)
);

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // vector: {is_read, expect_oe, req[3:0], addr[15:0], data[7:0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 4'd2, 16'h002E, 8'h05},
        {1'b1, 1'b1, 4'd2, 16'h002E, 8'h05},   // R2
        {1'b0, 1'b0, 4'd3, 16'h002F, 8'hFF},
        {1'b1, 1'b1, 4'd4, 16'h002F, 8'h3C},   // R4 reserved bits read 0
        {1'b0, 1'b0, 4'd2, 16'h002E, 8'h10},
        {1'b0, 1'b0, 4'd3, 16'h002F, 8'hA5},
        {1'b1, 1'b1, 4'd4, 16'h002F, 8'hA5},   // R4
        {1'b1, 1'b1, 4'd6, 16'h002E, 8'h10},   // R6
        {1'b0, 1'b0, 4'd2, 16'h002E, 8'h05},
        {1'b1, 1'b1, 4'd3, 16'h002F, 8'h3C},   // R3 value kept
        {1'b1, 1'b0, 4'd9, 16'h015C, 8'hFF},   // R9 other base
        {1'b0, 1'b0, 4'd9, 16'h012E, 8'h77},
        {1'b1, 1'b1, 4'd9, 16'h002E, 8'h05},   // R9 upper bits matter
        {1'b1, 1'b0, 4'd9, 16'h0030, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic [1:0]  strap_base = 2'b11;
    logic        pnp_unlock = 1'b0;
    logic [7:0]  cfg_idx;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [7:0]  cfg_mask;

    logic [7:0] rf [256];
    int n_chk = 0;
    int n_bad = 0;
    int n_cfgwr = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port i_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rdata_oe(bus_rdata_oe), .strap_base(strap_base),
        .pnp_unlock(pnp_unlock), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_mask(cfg_mask)
    );

    // Register bank model: index 5, 13, ... have reserved bits outside 3Ch
    always_comb begin
        cfg_rdata = rf[cfg_idx];
        cfg_mask  = (cfg_idx[2:0] == 3'd5) ? 8'h3C : 8'hFF;
    end
    always @(posedge clk) begin
        if (cfg_wr) begin
            rf[cfg_idx] <= cfg_wdata;
            n_cfgwr <= n_cfgwr + 1;
        end
        cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        strap_base = code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input string req, input logic [15:0] a,
                         input logic [7:0] exp, input logic exp_oe);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        check({req, " oe"}, {7'd0, bus_rdata_oe}, {7'd0, exp_oe});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        int wr_before;
        // R1 reset state, motherboard code 11
        do_reset(2'b11);
        bread("R1", 16'h002E, 8'h00, 1'b1);

        // vector walk, code 11
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][29])
                bread($sformatf("R%0d", VEC[i][27:24]), VEC[i][23:8], VEC[i][7:0], VEC[i][28]);
            else
                bwrite(VEC[i][23:8], VEC[i][7:0]);
        end

        // R5 code 10 base
        do_reset(2'b10);
        bread("R5", 16'h015C, 8'h00, 1'b1);
        bwrite(16'h015C, 8'h21);
        bwrite(16'h015D, 8'h6B);
        bread("R5", 16'h015D, 8'h6B, 1'b1);
        bread("R5", 16'h002E, 8'hFF, 1'b0);

        // R10 strap change after reset has no effect
        @(negedge clk);
        strap_base = 2'b00;
        repeat (2) @(negedge clk);
        bread("R10", 16'h015C, 8'h21, 1'b1);
        bread("R10", 16'h0279, 8'hFF, 1'b0);

        // R7 locked after plug-and-play reset
        do_reset(2'b01);
        wr_before = n_cfgwr;
        bread("R7", 16'h0279, 8'hFF, 1'b0);
        bwrite(16'h0279, 8'h09);
        bwrite(16'h027A, 8'h44);
        bread("R7", 16'h027A, 8'hFF, 1'b0);
        check("R7 cfg_wr count", 8'(n_cfgwr - wr_before), 8'h00);

        // R8 unlock pulse opens; locked write left no trace
        @(negedge clk);
        pnp_unlock = 1'b1;
        @(negedge clk);
        pnp_unlock = 1'b0;
        bread("R7 selector untouched", 16'h0279, 8'h00, 1'b1);
        bwrite(16'h0279, 8'h03);
        bwrite(16'hF27A, 8'h55);
        bread("R8", 16'h527A, 8'h55, 1'b1);
        bread("R8", 16'hA279, 8'h03, 1'b1);

        // R7 code 00 also locked
        do_reset(2'b00);
        bread("R7", 16'h0279, 8'hFF, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual %0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule